// File: doc/BRIEF.md
# TLB Access-Rights and Fault Checker

This block decides whether a memory access may proceed once the translation lookup has finished. It takes the looked-up entry (or the fact that the lookup missed), the privilege level of the requester, the kind of access, and a set of protection-identifier registers. From these it produces a three-bit permission mask (read, write, execute) for later accesses to the page, and a single four-bit fault code for the current access.

Privilege is numbered so that 0 is the most privileged level. Each entry carries two privilege bounds: an upper bound for reading (`ent_rd_pl`) and a lower bound for writing (`ent_wr_pl`). Execution is allowed only inside the window the two bounds form. A three-bit rights type says which of the three operations the page offers at all. A non-zero access identifier ties the page to the protection-identifier registers; a matching register takes write permission away. The dirty, break and reference flags of the entry add further faults. When several causes apply, one code is picked by a fixed priority.

The decision is combinational. It is captured in one output register, so each result appears one clock after its request. A debug request skips the rights checks and the flag checks. It still reports a miss.

Top module: `tlb_rights_chk`

## Requirements
- R1: Read permission (mask bit 0) is granted only when `priv <= ent_rd_pl` and the rights type offers read.
- R2: Write permission (mask bit 1) is granted only when `priv <= ent_wr_pl` and the rights type offers write.
- R3: Execute permission (mask bit 2) is granted only when `ent_wr_pl <= priv <= ent_rd_pl` and the rights type offers execute.
- R4: The rights type selects the offered operations:
  - 0: read only
  - 1: read and write
  - 2: read and execute
  - 3: read, write and execute
  - 4 to 7: execute only
- R5: An identifier match occurs when `pid_en` is 1, `ent_aid` is non-zero, and one of the four registers equals `{ent_aid, 1'b1}`. A match removes write permission. A write access (`acc` = 1) with a match gets fault 3. An access identifier of zero never matches.
- R6: On a miss (`hit` = 0), the mask is 0. The fault is 1 for an execute access (`acc` = 2) and 2 for any other access.
- R7: If the mask has no bit for the access, the fault is 4 for execute and 5 otherwise (`acc` 0 and 3 both mean read). The priority is: miss, then identifier fault, then rights fault, then the flag faults.
- R8: When the dirty flag is clear, write permission is removed, and a write access gets fault 6.
- R9: When the break flag is set, write permission is removed, and a write access gets fault 7. Fault 7 takes precedence over fault 6.
- R10: When the reference flag is set, the mask is reduced to execute only, and any non-execute access gets fault 8. Fault 8 takes precedence over faults 7 and 6.
- R11: With `dbg` set, no rights or flag fault is raised (an identifier match still clears write), while a miss is still reported as in R6.
- R12: Each result is presented one cycle after its request, marked by `res_vld`. After reset, or in a cycle after no request, `res_vld`, `perm` and `fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | A check request is present this cycle |
| hit | input | 1 | Lookup found an entry |
| dbg | input | 1 | Debug access: skip rights and flag checks |
| acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| priv | input | 2 | Current privilege level, 0 most privileged |
| pid_en | input | 1 | Enables the identifier check |
| pid_regs | input | 4*(AID_W+1) | Four identifier registers, register i at bits [i*(AID_W+1) +: AID_W+1] |
| ent_rd_pl | input | 2 | Entry read privilege bound |
| ent_wr_pl | input | 2 | Entry write privilege bound |
| ent_type | input | 3 | Entry rights type |
| ent_aid | input | AID_W | Entry access identifier (default 18 bits) |
| ent_dirty | input | 1 | Dirty flag |
| ent_brk | input | 1 | Break flag |
| ent_ref | input | 1 | Reference-trap flag |
| res_vld | output | 1 | Result valid |
| perm | output | 3 | Permission mask: bit 0 read, bit 1 write, bit 2 execute |
| fault | output | 4 | Fault code, 0 means none |

## Verification
Every result is due exactly one rising edge after the cycle that presents the request, and the output is otherwise zero. The driver applies a request on a falling edge and, in that same step, pushes the expected mask and code into a queue. The monitor compares on each falling edge where `res_vld` is high, so it pops the entry pushed one falling edge earlier. Back-to-back requests therefore test that the output holds one result per cycle, and idle cycles test that the output falls back to zero one edge later.

// File: rtl/tlb_rights_pkg.sv
package tlb_rights_pkg;

    localparam int PB_RD = 0;
    localparam int PB_WR = 1;
    localparam int PB_EX = 2;

    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    typedef enum logic [3:0] {
        FLT_NONE   = 4'd0,
        FLT_IMISS  = 4'd1,
        FLT_DMISS  = 4'd2,
        FLT_PID    = 4'd3,
        FLT_IPROT  = 4'd4,
        FLT_DRIGHT = 4'd5,
        FLT_DIRTY  = 4'd6,
        FLT_BREAK  = 4'd7,
        FLT_REF    = 4'd8
    } fault_e;

    typedef struct packed {
        logic       vld;
        logic [2:0] perm;
        fault_e     fault;
    } chk_res_t;

endpackage

// File: rtl/rights_mask.sv
module rights_mask #(
    parameter int PRIV_W = 2
) (
    input  logic [PRIV_W-1:0] priv,
    input  logic [PRIV_W-1:0] rd_pl,
    input  logic [PRIV_W-1:0] wr_pl,
    input  logic [2:0]        rtype,
    output logic [2:0]        mask
);
    import tlb_rights_pkg::*;

    logic rd_ok, wr_ok, ex_ok;

    always_comb begin
        rd_ok = (priv <= rd_pl);
        wr_ok = (priv <= wr_pl);
        ex_ok = (wr_pl <= priv) && (priv <= rd_pl);
        mask  = '0;
        case (rtype)
            3'd0: mask[PB_RD] = rd_ok;
            3'd1: begin
                mask[PB_RD] = rd_ok;
                mask[PB_WR] = wr_ok;
            end
            3'd2: begin
                mask[PB_RD] = rd_ok;
                mask[PB_EX] = ex_ok;
            end
            3'd3: begin
                mask[PB_RD] = rd_ok;
                mask[PB_WR] = wr_ok;
                mask[PB_EX] = ex_ok;
            end
            default: mask[PB_EX] = ex_ok;
        endcase
    end

endmodule

// File: rtl/pid_match.sv
module pid_match #(
    parameter int AID_W = 18,
    parameter int NPID  = 4
) (
    input  logic                        pid_en,
    input  logic [AID_W-1:0]            aid,
    input  logic [NPID*(AID_W+1)-1:0]   pid_regs,
    output logic                        match
);
    localparam int PID_W = AID_W + 1;

    logic [PID_W-1:0] key;
    logic [NPID-1:0]  eq;

    assign key = {aid, 1'b1};

    for (genvar g = 0; g < NPID; g++) begin : g_cmp
        assign eq[g] = (pid_regs[g*PID_W +: PID_W] == key);
    end

    assign match = pid_en && (aid != '0) && (|eq);

endmodule

// File: rtl/fault_sel.sv
module fault_sel (
    input  logic       hit,
    input  logic       dbg,
    input  logic [1:0] acc,
    input  logic       pid_hit,
    input  logic [2:0] mask_in,
    input  logic       dirty,
    input  logic       brk,
    input  logic       reftrap,
    output logic [2:0] perm,
    output tlb_rights_pkg::fault_e fault
);
    import tlb_rights_pkg::*;

    logic       is_wr, is_ex;
    logic [2:0] base;
    logic       need_ok;

    always_comb begin
        is_wr = (acc == ACC_WRITE);
        is_ex = (acc == ACC_EXEC);
        base  = mask_in;
        if (pid_hit) base[PB_WR] = 1'b0;
        need_ok = is_ex ? base[PB_EX] : (is_wr ? base[PB_WR] : base[PB_RD]);
        perm  = base;
        fault = FLT_NONE;

        if (!hit) begin
            perm  = '0;
            fault = is_ex ? FLT_IMISS : FLT_DMISS;
        end else if (pid_hit && is_wr && !dbg) begin
            fault = FLT_PID;
        end else if (dbg) begin
            fault = FLT_NONE;
        end else if (!need_ok) begin
            fault = is_ex ? FLT_IPROT : FLT_DRIGHT;
        end else begin
            // lowest priority first, later causes override
            if (!dirty) begin
                perm[PB_WR] = 1'b0;
                if (is_wr) fault = FLT_DIRTY;
            end
            if (brk) begin
                perm[PB_WR] = 1'b0;
                if (is_wr) fault = FLT_BREAK;
            end
            if (reftrap) begin
                perm = perm & 3'b100;
                if (!is_ex) fault = FLT_REF;
            end
        end
    end

endmodule

// File: rtl/tlb_rights_chk.sv
module tlb_rights_chk #(
    parameter int PRIV_W = 2,
    parameter int AID_W  = 18,
    parameter int NPID   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_vld,
    input  logic                        hit,
    input  logic                        dbg,
    input  logic [1:0]                  acc,
    input  logic [PRIV_W-1:0]           priv,
    input  logic                        pid_en,
    input  logic [NPID*(AID_W+1)-1:0]   pid_regs,
    input  logic [PRIV_W-1:0]           ent_rd_pl,
    input  logic [PRIV_W-1:0]           ent_wr_pl,
    input  logic [2:0]                  ent_type,
    input  logic [AID_W-1:0]            ent_aid,
    input  logic                        ent_dirty,
    input  logic                        ent_brk,
    input  logic                        ent_ref,
    output logic                        res_vld,
    output logic [2:0]                  perm,
    output logic [3:0]                  fault
);
    import tlb_rights_pkg::*;

    logic [2:0] type_mask;
    logic       id_hit;
    logic [2:0] sel_perm;
    fault_e     sel_fault;
    chk_res_t   res_d, res_q;

    rights_mask #(.PRIV_W(PRIV_W)) u_mask (
        .priv  (priv),
        .rd_pl (ent_rd_pl),
        .wr_pl (ent_wr_pl),
        .rtype (ent_type),
        .mask  (type_mask)
    );

    pid_match #(.AID_W(AID_W), .NPID(NPID)) u_pid (
        .pid_en   (pid_en),
        .aid      (ent_aid),
        .pid_regs (pid_regs),
        .match    (id_hit)
    );

    fault_sel u_sel (
        .hit     (hit),
        .dbg     (dbg),
        .acc     (acc),
        .pid_hit (id_hit),
        .mask_in (type_mask),
        .dirty   (ent_dirty),
        .brk     (ent_brk),
        .reftrap (ent_ref),
        .perm    (sel_perm),
        .fault   (sel_fault)
    );

    always_comb begin
        res_d.vld   = req_vld;
        res_d.perm  = req_vld ? sel_perm : 3'b000;
        res_d.fault = req_vld ? sel_fault : FLT_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_vld = res_q.vld;
    assign perm    = res_q.perm;
    assign fault   = res_q.fault;

    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && !hit |=> res_vld && perm == 3'b000 &&
                            (fault == 4'd1 || fault == 4'd2));

    // R10
    ref_exec_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld && fault == 4'd8 |-> perm[1:0] == 2'b00);

    // R11
    dbg_no_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && dbg |=> fault <= 4'd2);

    // R5
    pid_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld && fault == 4'd3 |-> !perm[1]);

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !res_vld && perm == 3'b000 && fault == 4'd0);

    // R8
    dirty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld && (fault == 4'd6 || fault == 4'd7) |-> !perm[1]);

endmodule

// File: tb/tb_tlb_rights_chk.sv
module tb_tlb_rights_chk;

    localparam int AID_W = 18;
    localparam int PID_W = AID_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             req_vld = 0, hit = 0, dbg = 0, pid_en = 0;
    logic [1:0]       acc = 0, priv = 0, rd_pl = 0, wr_pl = 0;
    logic [2:0]       etype = 0;
    logic [AID_W-1:0] aid = 0;
    logic             dflag = 0, bflag = 0, tflag = 0;
    logic [PID_W-1:0] pidr [4];
    logic [4*PID_W-1:0] pid_flat;
    logic             res_vld;
    logic [2:0]       perm;
    logic [3:0]       fault;

    always_comb
        for (int i = 0; i < 4; i++) pid_flat[i*PID_W +: PID_W] = pidr[i];

    tlb_rights_chk dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .hit(hit), .dbg(dbg),
        .acc(acc), .priv(priv), .pid_en(pid_en), .pid_regs(pid_flat),
        .ent_rd_pl(rd_pl), .ent_wr_pl(wr_pl), .ent_type(etype), .ent_aid(aid),
        .ent_dirty(dflag), .ent_brk(bflag), .ent_ref(tflag),
        .res_vld(res_vld), .perm(perm), .fault(fault)
    );

    // staging values, copied to the DUT inputs by send()
    logic s_hit, s_dbg, s_pen, s_d, s_b, s_t;
    logic [1:0] s_acc, s_priv, s_rpl, s_wpl;
    logic [2:0] s_type;
    logic [AID_W-1:0] s_aid;

    int n_chk = 0, n_fail = 0;
    logic [6:0] exp_q [$];
    string      tag_q [$];

    function automatic logic [6:0] model();
        logic [2:0] m;
        logic [3:0] f;
        logic r, w, x, idm, wr, ex, ok;
        r = s_priv <= s_rpl;
        w = s_priv <= s_wpl;
        x = (s_wpl <= s_priv) && (s_priv <= s_rpl);
        case (s_type)
            0: m = {1'b0, 1'b0, r};
            1: m = {1'b0, w, r};
            2: m = {x, 1'b0, r};
            3: m = {x, w, r};
            default: m = {x, 1'b0, 1'b0};
        endcase
        idm = 0;
        for (int i = 0; i < 4; i++)
            if (s_pen && s_aid != 0 && pidr[i] == {s_aid, 1'b1}) idm = 1;
        if (idm) m[1] = 0;
        wr = s_acc == 1;
        ex = s_acc == 2;
        ok = ex ? m[2] : (wr ? m[1] : m[0]);
        f = 0;
        if (!s_hit) begin m = 0; f = ex ? 4'd1 : 4'd2; end
        else if (idm && wr && !s_dbg) f = 3;
        else if (s_dbg) f = 0;
        else if (!ok) f = ex ? 4'd4 : 4'd5;
        else begin
            if (s_t) begin m = m & 3'b100; if (!ex) f = 8; end
            else begin
                if (!s_d || s_b) m[1] = 0;
                if (s_b && wr) f = 7;
                else if (!s_d && wr) f = 6;
            end
        end
        return {m, f};
    endfunction

    task automatic send(input string tag);
        @(negedge clk);
        req_vld = 1; hit = s_hit; dbg = s_dbg; pid_en = s_pen; acc = s_acc;
        priv = s_priv; rd_pl = s_rpl; wr_pl = s_wpl; etype = s_type;
        aid = s_aid; dflag = s_d; bflag = s_b; tflag = s_t;
        exp_q.push_back(model());
        tag_q.push_back(tag);
    endtask

    task automatic ent(input logic [1:0] rp, wp, input logic [2:0] ty,
                       input logic d, b, t);
        s_hit = 1; s_dbg = 0; s_rpl = rp; s_wpl = wp; s_type = ty;
        s_d = d; s_b = b; s_t = t; s_pen = 0; s_aid = 0;
    endtask

    task automatic go(input logic [1:0] a, p, input string tag);
        s_acc = a; s_priv = p;
        send(tag);
    endtask

    // monitor: results are due one edge after the request
    always @(negedge clk) begin
        if (rst_n && res_vld) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R12 unexpected result perm=%b fault=%0d expected none",
                         perm, fault);
            end else begin
                logic [6:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({perm, fault} !== e) begin
                    n_fail++;
                    $display("FAIL %s perm=%b fault=%0d expected perm=%b fault=%0d",
                             t, perm, fault, e[6:4], e[3:0]);
                end
            end
        end
    end

    task automatic idle_check(input string tag);
        @(negedge clk); req_vld = 0;
        @(negedge clk);
        n_chk++;
        if (res_vld !== 0 || perm !== 0 || fault !== 0 || exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s vld=%b perm=%b fault=%0d pending=%0d expected 0/000/0/0",
                     tag, res_vld, perm, fault, exp_q.size());
        end
    endtask

    bit finished = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) pidr[i] = '0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (res_vld !== 0 || perm !== 0 || fault !== 0) begin
            n_fail++;
            $display("FAIL R12 reset vld=%b perm=%b fault=%0d expected 0/000/0",
                     res_vld, perm, fault);
        end
        rst_n = 1;

        // R4 type table
        ent(3, 3, 0, 1, 0, 0); go(0, 0, "R4 type0 read");
        ent(3, 0, 1, 1, 0, 0); go(1, 0, "R4 type1 write");
        ent(2, 1, 3, 1, 0, 0); go(2, 1, "R4 type3 exec");
        ent(3, 0, 5, 1, 0, 0); go(0, 0, "R4 type5 read denied");
        ent(3, 0, 6, 1, 0, 0); go(2, 2, "R4 type6 exec");
        // R1 / R2 / R3 privilege bounds
        ent(1, 1, 0, 1, 0, 0); go(0, 2, "R1 read above bound");
        ent(1, 1, 0, 1, 0, 0); go(3, 1, "R1 read at bound");
        ent(3, 1, 1, 1, 0, 0); go(1, 2, "R2 write above bound");
        ent(2, 0, 2, 1, 0, 0); go(2, 3, "R3 exec above window");
        ent(3, 1, 2, 1, 0, 0); go(2, 0, "R3 exec below window");
        // R6 miss
        ent(3, 3, 3, 1, 0, 0); s_hit = 0; go(2, 0, "R6 miss exec");
        ent(3, 3, 3, 1, 0, 0); s_hit = 0; go(1, 0, "R6 miss write");
        // R5 identifier
        pidr[2] = {18'd5, 1'b1};
        pidr[1] = {18'd9, 1'b0};
        pidr[0] = 19'd1;
        ent(3, 0, 3, 1, 0, 0); s_pen = 1; s_aid = 5; go(1, 0, "R5 match write");
        ent(3, 0, 3, 1, 0, 0); s_pen = 1; s_aid = 5; go(0, 0, "R5 match read");
        ent(3, 0, 3, 1, 0, 0); s_pen = 1; s_aid = 9; go(1, 0, "R5 low bit clear");
        ent(3, 0, 3, 1, 0, 0); s_pen = 1; s_aid = 0; go(1, 0, "R5 public page");
        ent(3, 0, 3, 1, 0, 0); s_pen = 0; s_aid = 5; go(1, 0, "R5 check disabled");
        // R7 priority
        ent(3, 0, 3, 1, 0, 0); s_pen = 1; s_aid = 5; s_hit = 0; go(1, 0, "R7 miss over id");
        ent(3, 0, 5, 0, 1, 1); go(0, 0, "R7 rights over flags");
        // R8 / R9 / R10 flags
        ent(3, 0, 1, 0, 0, 0); go(1, 0, "R8 dirty write");
        ent(3, 0, 1, 0, 0, 0); go(0, 0, "R8 dirty read");
        ent(3, 0, 1, 0, 1, 0); go(1, 0, "R9 break over dirty");
        ent(3, 0, 1, 1, 1, 0); go(0, 0, "R9 break read");
        ent(3, 0, 3, 0, 1, 1); go(1, 0, "R10 ref over break");
        ent(3, 0, 3, 1, 0, 1); go(2, 0, "R10 ref exec");
        ent(3, 0, 3, 1, 0, 1); go(0, 1, "R10 ref read");
        // R11 debug
        ent(0, 0, 0, 1, 0, 0); s_dbg = 1; go(1, 3, "R11 dbg no rights");
        ent(3, 0, 3, 0, 1, 1); s_dbg = 1; go(0, 0, "R11 dbg no flags");
        ent(3, 0, 3, 1, 0, 0); s_dbg = 1; s_hit = 0; go(2, 0, "R11 dbg miss");
        ent(3, 0, 3, 1, 0, 0); s_dbg = 1; s_pen = 1; s_aid = 5; go(1, 0, "R11 dbg id");
        idle_check("R12 idle after burst");

        // mixed traffic
        for (int k = 0; k < 600; k++) begin
            s_hit = ($urandom % 8) != 0; s_dbg = ($urandom % 6) == 0;
            s_pen = $urandom % 2; s_aid = ($urandom % 4 == 0) ? 18'd0 : 18'($urandom % 12);
            s_acc = 2'($urandom); s_priv = 2'($urandom);
            s_rpl = 2'($urandom); s_wpl = 2'($urandom); s_type = 3'($urandom);
            s_d = $urandom % 2; s_b = $urandom % 2; s_t = ($urandom % 4) == 0;
            send("R1 R2 R3 R4 R5 R7 mixed");
            if (k % 97 == 0) idle_check("R12 idle gap");
        end
        idle_check("R12 idle at end");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule